// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block gives each hart of a cluster its machine timer interrupt and its software interrupt. It keeps one shared 64-bit time counter, which advances on an enable strobe. Each hart has its own 64-bit compare register and a one-bit software-pending flag. Each hart gets two interrupt lines. The timer line is high while the time counter has reached that hart's compare value. The software line follows the hart's pending flag.

Software reaches every register through a plain 32-bit word port, with one cycle of read latency. Addresses are word indices. Each 64-bit register spans two consecutive words, and the low half sits at the lower index. To arm a timer, software reads the time counter and then writes a compare value above it. Writing a compare value above the current time withdraws the interrupt. One hart signals another by writing 1 to the target's pending flag. The target clears the flag by writing 0.

Top module: `ctsi_unit`

## Requirements
- R1: After reset, the time counter reads 0 and every compare register reads all-ones. Every pending flag reads 0, every interrupt line is low and `reg_rdata` is 0.
- R2: Each clock edge with `tick_en` high adds one to the time counter. With `tick_en` low the counter keeps its value.
- R3: The time counter wraps from 2^64-1 to 0 on a tick.
- R4: A write to word 2^AW-2 replaces the low half of the time counter, and a write to word 2^AW-1 replaces the high half. In a cycle that has such a write, the tick is dropped, so the written half takes exactly the written value and the other half keeps its value.
- R5: The timer line of hart h is high exactly when the time counter, taken as an unsigned number, is greater than or equal to compare register h. The line follows any register change in the same cycle that the change takes effect.
- R6: Compare register h takes its low half from a write to word 2^(AW-1)+2h and its high half from a write to word 2^(AW-1)+2h+1. Both halves read back at the same word indices.
- R7: A write to word h (h below NUM_HARTS) sets the pending flag of hart h to bit 0 of the write data. The software line of hart h equals that flag.
- R8: Bits 31:1 of a pending word always read as 0, and their written values are discarded.
- R9: When `reg_rd` is high at a clock edge, `reg_rdata` shows the addressed word after that edge. The value is the one held before any write made at the same edge. After an edge without a read, `reg_rdata` is 0.
- R10: A read of any word outside the map returns 0. A write to such a word changes no register and no interrupt line.
- R11: A write aimed at one hart changes no other hart's compare register, pending flag or interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Time-base advance strobe |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | AW | Word index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt |

## Verification
The properties assume that `tick_en`, `reg_wr`, `reg_rd` and `reg_addr` are driven to known values in every cycle after reset. They also assume that the time counter is only reloaded through its two words, since the hold and step checks are keyed on a write to a time word. The stimulus changes inputs only on the falling edge and holds them at idle between transactions. It runs the ticking phases only while no time word is written, except for the one deliberate collision case that exercises R4.

// File: rtl/ctsi_pkg.sv
// Package: shared constants and types for the core-local timer and
// software interrupt unit. Assumes a 32-bit register port and a 64-bit
// time base.
package ctsi_pkg;
    localparam int unsigned CTSI_DW = 32;
    localparam int unsigned CTSI_TW = 2 * CTSI_DW;

    // Which register class an address hits
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SOFT = 2'd1,
        SEL_CMP  = 2'd2,
        SEL_TIME = 2'd3
    } ctsi_sel_e;
endpackage

// File: rtl/ctsi_addr_decode.sv
// Address decoder: turns a word index into a register class, a hart
// index and a high-half flag. Assumes NUM_HARTS fits below the compare
// window and that the compare window ends below the two time words.
module ctsi_addr_decode
    import ctsi_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int AW        = 10
) (
    input  logic [AW-1:0]   addr,
    output ctsi_sel_e       sel,
    output logic [((NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1)-1:0] idx,
    output logic            hi
);
    localparam int IDXW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
    localparam logic [AW-1:0] SOFT_END = AW'(NUM_HARTS);
    localparam logic [AW-1:0] CMP_BASE = AW'(2 ** (AW - 1));
    localparam logic [AW-1:0] CMP_END  = AW'(2 ** (AW - 1) + 2 * NUM_HARTS);
    localparam logic [AW-1:0] TIME_LO  = AW'(2 ** AW - 2);

    logic [IDXW:0] cmp_off;

    // Classify the address and extract hart index and word half
    always_comb begin
        sel     = SEL_NONE;
        idx     = '0;
        hi      = 1'b0;
        cmp_off = (IDXW + 1)'(addr - CMP_BASE);
        if (addr < SOFT_END) begin
            sel = SEL_SOFT;
            idx = addr[IDXW-1:0];
        end else if (addr >= CMP_BASE && addr < CMP_END) begin
            sel = SEL_CMP;
            idx = cmp_off[IDXW:1];
            hi  = cmp_off[0];
        end else if (addr >= TIME_LO) begin
            sel = SEL_TIME;
            hi  = addr[0];
        end
    end
endmodule

// File: rtl/ctsi_time_base.sv
// Time base: free-running 64-bit counter advanced by a tick strobe,
// with word-wise reload. A reload of either half drops that cycle's tick.
module ctsi_time_base
    import ctsi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CTSI_DW-1:0] wdata,
    output logic [CTSI_TW-1:0] time_q
);
    // Reload a half, or advance by one, wrapping at 2^64
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (wr_lo) begin
            time_q[CTSI_DW-1:0] <= wdata;
        end else if (wr_hi) begin
            time_q[CTSI_TW-1:CTSI_DW] <= wdata;
        end else if (tick_en) begin
            time_q <= time_q + CTSI_TW'(1);
        end
    end
endmodule

// File: rtl/ctsi_hart_slot.sv
// Per-hart slot: compare register, software-pending flag and the two
// interrupt lines. The timer line is an unsigned magnitude compare
// against the shared time value.
module ctsi_hart_slot
    import ctsi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CTSI_TW-1:0] time_now,
    input  logic               cmp_wr_lo,
    input  logic               cmp_wr_hi,
    input  logic               soft_wr,
    input  logic               soft_bit,
    input  logic [CTSI_DW-1:0] wdata,
    output logic [CTSI_TW-1:0] cmp_q,
    output logic               soft_q,
    output logic               timer_irq,
    output logic               soft_irq
);
    // Compare register: resets to all-ones so no timer fires early
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_wr_lo) begin
            cmp_q[CTSI_DW-1:0] <= wdata;
        end else if (cmp_wr_hi) begin
            cmp_q[CTSI_TW-1:CTSI_DW] <= wdata;
        end
    end

    // Software-pending flag: only bit 0 of the write is kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (soft_wr) begin
            soft_q <= soft_bit;
        end
    end

    // Interrupt lines
    assign timer_irq = (time_now >= cmp_q);
    assign soft_irq  = soft_q;
endmodule

// File: rtl/ctsi_unit.sv
// Top: core-local timer and software interrupt unit. One shared time
// base, NUM_HARTS slots, a word decoder and a registered read port.
// Assumes reg_addr is a word index and read data is taken one cycle
// after the request.
module ctsi_unit
    import ctsi_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int AW        = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [AW-1:0]        reg_addr,
    input  logic [CTSI_DW-1:0]   reg_wdata,
    output logic [CTSI_DW-1:0]   reg_rdata,
    output logic [NUM_HARTS-1:0] timer_irq,
    output logic [NUM_HARTS-1:0] soft_irq
);
    localparam int IDXW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    ctsi_sel_e          sel;
    logic [IDXW-1:0]    idx;
    logic               hi;
    logic [CTSI_TW-1:0] time_q;
    logic [CTSI_TW-1:0] cmp_all  [NUM_HARTS];
    logic               soft_all [NUM_HARTS];
    logic [CTSI_DW-1:0] rd_mux;
    logic [CTSI_DW-1:0] rdata_q;

    ctsi_addr_decode #(
        .NUM_HARTS (NUM_HARTS),
        .AW        (AW)
    ) dec_i (
        .addr (reg_addr),
        .sel  (sel),
        .idx  (idx),
        .hi   (hi)
    );

    ctsi_time_base tb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_lo   (reg_wr && sel == SEL_TIME && !hi),
        .wr_hi   (reg_wr && sel == SEL_TIME && hi),
        .wdata   (reg_wdata),
        .time_q  (time_q)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic hit;
        assign hit = (idx == IDXW'(h));

        ctsi_hart_slot slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .time_now  (time_q),
            .cmp_wr_lo (reg_wr && sel == SEL_CMP && hit && !hi),
            .cmp_wr_hi (reg_wr && sel == SEL_CMP && hit && hi),
            .soft_wr   (reg_wr && sel == SEL_SOFT && hit),
            .soft_bit  (reg_wdata[0]),
            .wdata     (reg_wdata),
            .cmp_q     (cmp_all[h]),
            .soft_q    (soft_all[h]),
            .timer_irq (timer_irq[h]),
            .soft_irq  (soft_irq[h])
        );
    end

    // Select the addressed word; unmapped words give zero
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_SOFT: rd_mux = {{(CTSI_DW-1){1'b0}}, soft_all[idx]};
            SEL_CMP:  rd_mux = hi ? cmp_all[idx][CTSI_TW-1:CTSI_DW]
                                  : cmp_all[idx][CTSI_DW-1:0];
            SEL_TIME: rd_mux = hi ? time_q[CTSI_TW-1:CTSI_DW]
                                  : time_q[CTSI_DW-1:0];
            default:  rd_mux = '0;
        endcase
    end

    // Register read data; zero after a cycle without a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= reg_rd ? rd_mux : '0;
        end
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/ctsi_unit_chk.sv
// Checker for ctsi_unit: temporal properties on the port and on the
// time base, attached by bind.
module ctsi_unit_chk
    import ctsi_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int AW        = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [AW-1:0]        reg_addr,
    input logic [CTSI_DW-1:0]   reg_rdata,
    input logic [NUM_HARTS-1:0] timer_irq,
    input logic [NUM_HARTS-1:0] soft_irq,
    input logic [CTSI_TW-1:0]   time_now
);
    localparam logic [AW-1:0] SOFT_END = AW'(NUM_HARTS);
    localparam logic [AW-1:0] CMP_BASE = AW'(2 ** (AW - 1));
    localparam logic [AW-1:0] CMP_END  = AW'(2 ** (AW - 1) + 2 * NUM_HARTS);
    localparam logic [AW-1:0] TIME_LO  = AW'(2 ** AW - 2);

    logic time_hit;
    logic mapped;
    assign time_hit = (reg_addr >= TIME_LO);
    assign mapped   = (reg_addr < SOFT_END) ||
                      (reg_addr >= CMP_BASE && reg_addr < CMP_END) || time_hit;

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !(reg_wr && time_hit)) |=> (time_now == $past(time_now) + CTSI_TW'(1))); // R2
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(reg_wr && time_hit)) |=> $stable(time_now)); // R2
    AST_TIME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !(reg_wr && time_hit) && time_now == '1) |=> (time_now == '0)); // R3
    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !reg_wr) |=> $stable(timer_irq)); // R5
    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(soft_irq)); // R7
    AST_SOFT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr < SOFT_END) |=> (reg_rdata[CTSI_DW-1:1] == '0)); // R8
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0)); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !mapped) |=> (reg_rdata == '0)); // R10
endmodule

bind ctsi_unit ctsi_unit_chk #(
    .NUM_HARTS (NUM_HARTS),
    .AW        (AW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .timer_irq (timer_irq),
    .soft_irq  (soft_irq),
    .time_now  (time_q)
);

// File: tb/ctsi_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps the whole word map and the compare boundaries of a
// four-hart unit against an arithmetic model kept in the bench.
module ctsi_unit_tb_top;
    localparam int NH = 4;
    localparam int AW = 10;
    localparam int CB = 512;
    localparam int TL = 1022;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NH-1:0] timer_irq;
    logic [NH-1:0] soft_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [63:0] exp_time;
    logic [63:0] exp_cmp [NH];
    logic        exp_soft [NH];

    ctsi_unit #(.NUM_HARTS(NH), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .timer_irq(timer_irq), .soft_irq(soft_irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_mapped(input int a);
        return (a < NH) || (a >= CB && a < CB + 2 * NH) || (a >= TL);
    endfunction

    function automatic logic [31:0] model_read(input int a);
        logic [63:0] v;
        if (a < NH) return {31'b0, exp_soft[a]};
        if (a >= CB && a < CB + 2 * NH) begin
            v = exp_cmp[(a - CB) / 2];
            return ((a - CB) % 2 == 1) ? v[63:32] : v[31:0];
        end
        if (a == TL) return exp_time[31:0];
        if (a == TL + 1) return exp_time[63:32];
        return 32'h0;
    endfunction

    task automatic model_write(input int a, input logic [31:0] d);
        if (a < NH) exp_soft[a] = d[0];
        else if (a >= CB && a < CB + 2 * NH) begin
            if ((a - CB) % 2 == 1) exp_cmp[(a - CB) / 2][63:32] = d;
            else exp_cmp[(a - CB) / 2][31:0] = d;
        end
        else if (a == TL) exp_time[31:0] = d;
        else if (a == TL + 1) exp_time[63:32] = d;
    endtask

    task automatic bwr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic brd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a); reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input int a);
        logic [31:0] d;
        brd(a, d);
        chk(req, d, model_read(a));
    endtask

    task automatic irq_chk(input string req);
        logic [NH-1:0] et, es;
        for (int h = 0; h < NH; h++) begin
            et[h] = (exp_time >= exp_cmp[h]);
            es[h] = exp_soft[h];
        end
        chk(req, {24'b0, timer_irq, soft_irq}, {24'b0, et, es});
    endtask

    task automatic tick_n(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        exp_time = exp_time + 64'(n);
    endtask

    task automatic set_time(input logic [63:0] t);
        bwr(TL, t[31:0]);
        bwr(TL + 1, t[63:32]);
    endtask

    task automatic set_cmp(input int h, input logic [63:0] c);
        bwr(CB + 2 * h, c[31:0]);
        bwr(CB + 2 * h + 1, c[63:32]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [63:0] tv [3];
        exp_time = '0;
        for (int h = 0; h < NH; h++) begin exp_cmp[h] = '1; exp_soft[h] = 1'b0; end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        irq_chk("R1 lines");
        for (int a = 0; a < (1 << AW); a++) rd_chk("R1 map sweep", a);

        // R7, R8, R11: software-pending flags
        bwr(0, 32'hFFFF_FFFE);
        rd_chk("R8 upper ignored", 0);
        bwr(2, 32'hFFFF_FFFF);
        rd_chk("R8 bit0 only", 2);
        irq_chk("R7 R11 set hart2");
        bwr(1, 32'h1);
        irq_chk("R7 set hart1");
        bwr(2, 32'h0);
        irq_chk("R7 R11 clear hart2");

        // R9: read and write at one edge returns the old value
        @(negedge clk);
        reg_addr = AW'(3); reg_wdata = 32'h1; reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        chk("R9 old value", reg_rdata, 32'h0);
        model_write(3, 32'h1);
        @(negedge clk);
        chk("R9 idle zero", reg_rdata, 32'h0);
        rd_chk("R9 new value", 3);

        // R5, R6, R11: compare boundaries around several time points
        tv[0] = 64'h0000_0001_0000_0000;
        tv[1] = 64'h1234_5678_9ABC_DEF0;
        tv[2] = 64'hFFFF_FFFF_FFFF_FFFD;
        for (int i = 0; i < 3; i++) begin
            set_time(tv[i]);
            for (int h = 0; h < NH; h++) begin
                for (int dd = -2; dd <= 2; dd++) begin
                    set_cmp(h, tv[i] + 64'(dd));
                    irq_chk("R5 R11 compare");
                end
                rd_chk("R6 cmp lo", CB + 2 * h);
                rd_chk("R6 cmp hi", CB + 2 * h + 1);
            end
        end
        set_cmp(0, 64'h0000_0000_FFFF_FFFF);
        set_time(64'h0000_0001_0000_0000);
        irq_chk("R5 high word decides");

        // R3: wrap through 2^64
        set_time(64'hFFFF_FFFF_FFFF_FFFE);
        tick_n(3);
        rd_chk("R3 wrap lo", TL);
        rd_chk("R3 wrap hi", TL + 1);

        // R2: counting and holding
        set_time(64'd100);
        tick_n(7);
        rd_chk("R2 count lo", TL);
        rd_chk("R2 count hi", TL + 1);
        repeat (5) @(negedge clk);
        rd_chk("R2 hold", TL);

        // R5: timer line rises as time reaches the compare value
        set_cmp(1, 64'd110);
        irq_chk("R5 below");
        tick_n(2);
        irq_chk("R5 one below");
        tick_n(1);
        irq_chk("R5 equal");
        tick_n(1);
        irq_chk("R5 above");
        set_cmp(1, 64'd500);
        irq_chk("R5 rearm clears");

        // R4: a time write drops the tick of the same cycle
        set_time(64'h0000_0007_FFFF_FFF0);
        @(negedge clk);
        tick_en = 1'b1; reg_wr = 1'b1; reg_addr = AW'(TL); reg_wdata = 32'h55;
        @(negedge clk);
        tick_en = 1'b0; reg_wr = 1'b0;
        exp_time[31:0] = 32'h55;
        rd_chk("R4 collide lo", TL);
        rd_chk("R4 collide hi", TL + 1);
        @(negedge clk);
        tick_en = 1'b1; reg_wr = 1'b1; reg_addr = AW'(TL + 1); reg_wdata = 32'h9;
        @(negedge clk);
        tick_en = 1'b0; reg_wr = 1'b0;
        exp_time[63:32] = 32'h9;
        rd_chk("R4 collide hi2", TL + 1);
        rd_chk("R4 collide lo2", TL);

        // R10: write all-ones to every unmapped word, then resweep
        for (int a = 0; a < (1 << AW); a++)
            if (!is_mapped(a)) bwr(a, 32'hFFFF_FFFF);
        irq_chk("R10 lines unchanged");
        for (int a = 0; a < (1 << AW); a++) rd_chk("R10 map sweep", a);

        finish_run();
    end
endmodule